// File: doc/BRIEF.md
# Dual-Core Interrupt Routing Matrix

This block steers a set of peripheral request lines onto the interrupt slots of two processor cores. Each external source owns a route word that names a core, one of that core's 32 slots, and an enable. Several sources may be steered to the same slot, where they are ORed together. Each core also has six private request lines: three timer compares, one performance monitor and two software requests. These are wired permanently to six reserved slots of that core. No route word can reach a reserved slot.

Every slot has a fixed priority level from 1 to 7 and a fixed trigger type, both set by parameters. A level-type slot is pending while its combined input is high. An edge-type slot latches a rising edge of its combined input and holds it until the core clears it with a write-one-to-clear access. For each core the block presents the highest-priority slot that is both pending and enabled in that core's 32-bit mask. Ties go to the lowest index.

Configuration is a plain synchronous write port with three independent strobes: one for route words, one for masks and one for clears. A route write that names a reserved slot is dropped, and it raises a sticky error flag.

Top module: `irq_router`

## Requirements
- R1: After reset every route word is disabled, both masks are zero, no slot is pending, both valid outputs are low and `routeErr` is low.
- R2: A route word is 7 bits: bit 6 enables the source, bit 5 selects the core (0 or 1) and bits 4:0 give the slot. A write takes effect at the clock edge that samples `cfgWrEn`.
- R3: A level-type slot is pending exactly while at least one enabled source routed to it, or its internal line, is high. The pending state is registered one clock after the inputs.
- R4: An edge-type slot sets its pending bit on a low-to-high change of its combined input. The bit holds until cleared. Extra edges while it is set are merged. If a clear and a new edge arrive in the same cycle, the bit stays set.
- R5: Writing a one through the clear port to a level-type slot has no effect on that slot.
- R6: A route write whose slot field names a reserved slot leaves that source's route word unchanged and sets `routeErr`. `routeErr` stays set until reset.
- R7: Bit k (0..5) of a core's internal request input drives only slot 26+k of that same core. The bits are ordered timer0, timer1, timer2, performance monitor, software0, software1.
- R8: A source whose enable bit is 0 does not affect any slot, whatever its request line does.
- R9: Per core, the valid output is high when some slot is both pending and mask-enabled. The slot output is the one with the highest level among those slots, with the lowest index winning ties. The level output is that slot's fixed level. All three outputs follow the registered state with no further delay.
- R10: A mask write replaces the whole 32-bit mask of the selected core. A masked slot keeps its pending state but takes no part in selection.
- R11: Default slot table, identical on both cores:
  - Levels: slots 0-9 and 24-26 and 30 are level 1; slots 10-13 are level 2; slots 14-17, 27 and 31 are level 3; slots 18-19 are level 4; slots 20-21 and 28 are level 5; slot 22 is level 6; slots 23 and 29 are level 7.
  - Edge type: slots 8, 9, 13, 17, 20, 26, 27, 28 and 30.
  - Reserved: slots 26-31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extReq | input | NUM_SRC | External peripheral request lines |
| core0IntReq | input | 6 | Core 0 internal requests (timer0..2, perf, sw0..1) |
| core1IntReq | input | 6 | Core 1 internal requests |
| cfgWrEn | input | 1 | Route word write strobe |
| cfgWrSel | input | clog2(NUM_SRC) | Source whose route word is written |
| cfgWrData | input | 7 | Route word {enable, core, slot} |
| maskWrEn | input | 1 | Mask write strobe |
| maskWrCore | input | 1 | Core whose mask is written |
| maskWrData | input | 32 | New slot-enable mask |
| clrWrEn | input | 1 | Edge-pending clear strobe |
| clrWrCore | input | 1 | Core whose edge bits are cleared |
| clrWrData | input | 32 | Write-one-to-clear bit set |
| routeErr | output | 1 | Sticky flag for a rejected route write |
| core0Valid | output | 1 | Core 0 has a qualifying slot |
| core0Slot | output | 5 | Core 0 winning slot index |
| core0Level | output | 3 | Core 0 winning slot level |
| core1Valid | output | 1 | Core 1 has a qualifying slot |
| core1Slot | output | 5 | Core 1 winning slot index |
| core1Level | output | 3 | Core 1 winning slot level |

## Verification
A request change, a clear or a route change to an active source reaches the selection outputs after one or two register stages. A request or clear shows after the next rising edge. A route change shows after two edges: the route word is updated first, then the pending bit. Mask writes and the error flag show right after the edge that samples them. The bench drives inputs and checks outputs on the falling edge. Its behavioural model updates on the rising edge in the same order: slot inputs are built from the old route words, pending bits are updated, and only then are the writes applied. As a result, every comparison lands exactly in the cycle the result is due. Hand-written checks at fixed points cover shared level slots, merged edges, clears that coincide with an edge, masked winners and rejected writes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NUM_CORES    = 2;
  localparam int NUM_SLOTS    = 32;
  localparam int SLOT_W       = 5;
  localparam int LVL_W        = 3;
  localparam int INT_PER_CORE = 6;

  // route word: enable is bit 6, core bit 5, slot bits 4:0
  typedef struct packed {
    logic             en;
    logic             core;
    logic [SLOT_W-1:0] slot;
  } route_t;

  // strobes from control to the slot datapath
  typedef struct packed {
    logic [NUM_CORES-1:0] clrHit;
    logic [NUM_SLOTS-1:0] clrBits;
  } strobe_t;

  function automatic logic [NUM_SLOTS*LVL_W-1:0] defaultLevels();
    logic [NUM_SLOTS*LVL_W-1:0] t;
    t = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      logic [LVL_W-1:0] v;
      if (s <= 9) v = 3'd1;
      else if (s <= 13) v = 3'd2;
      else if (s <= 17) v = 3'd3;
      else if (s <= 19) v = 3'd4;
      else if (s <= 21) v = 3'd5;
      else if (s == 22) v = 3'd6;
      else if (s == 23) v = 3'd7;
      else if (s <= 26) v = 3'd1;
      else if (s == 27) v = 3'd3;
      else if (s == 28) v = 3'd5;
      else if (s == 29) v = 3'd7;
      else if (s == 30) v = 3'd1;
      else v = 3'd3;
      t[s*LVL_W +: LVL_W] = v;
    end
    return t;
  endfunction

  function automatic logic [NUM_SLOTS-1:0] defaultEdges();
    logic [NUM_SLOTS-1:0] e;
    e = '0;
    e[8] = 1'b1; e[9] = 1'b1; e[13] = 1'b1; e[17] = 1'b1; e[20] = 1'b1;
    e[26] = 1'b1; e[27] = 1'b1; e[28] = 1'b1; e[30] = 1'b1;
    return e;
  endfunction

  function automatic logic [INT_PER_CORE*SLOT_W-1:0] defaultIntSlots();
    logic [INT_PER_CORE*SLOT_W-1:0] m;
    for (int k = 0; k < INT_PER_CORE; k++) m[k*SLOT_W +: SLOT_W] = SLOT_W'(26 + k);
    return m;
  endfunction

  function automatic logic [NUM_SLOTS-1:0] reservedMask(
      input logic [INT_PER_CORE*SLOT_W-1:0] intSlots);
    logic [NUM_SLOTS-1:0] r;
    r = '0;
    for (int k = 0; k < INT_PER_CORE; k++) r[intSlots[k*SLOT_W +: SLOT_W]] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_router_pkg::*;
#(
  parameter logic [NUM_SLOTS*LVL_W-1:0] SLOT_LEVEL = defaultLevels()
) (
  input  logic [NUM_SLOTS-1:0] cand,
  output logic                 pickValid,
  output logic [SLOT_W-1:0]    pickSlot,
  output logic [LVL_W-1:0]     pickLevel
);
  always_comb begin
    pickValid = 1'b0;
    pickSlot  = '0;
    pickLevel = '0;
    // ascending scan with strict compare keeps the lower index on ties
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (cand[s] && (!pickValid || SLOT_LEVEL[s*LVL_W +: LVL_W] > pickLevel)) begin
        pickValid = 1'b1;
        pickSlot  = SLOT_W'(s);
        pickLevel = SLOT_LEVEL[s*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [INT_PER_CORE*SLOT_W-1:0] INT_SLOTS = defaultIntSlots(),
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrEn,
  input  logic [SEL_W-1:0]              cfgWrSel,
  input  logic [6:0]                    cfgWrData,
  input  logic                          maskWrEn,
  input  logic                          maskWrCore,
  input  logic [NUM_SLOTS-1:0]          maskWrData,
  input  logic                          clrWrEn,
  input  logic                          clrWrCore,
  input  logic [NUM_SLOTS-1:0]          clrWrData,
  output route_t [NUM_SRC-1:0]          routes,
  output logic [NUM_CORES-1:0][NUM_SLOTS-1:0] coreMask,
  output strobe_t                       strobe,
  output logic                          routeErr
);
  localparam logic [NUM_SLOTS-1:0] RESERVED = reservedMask(INT_SLOTS);

  route_t newRoute;
  logic   selOk;
  logic   hitReserved;

  assign newRoute    = route_t'(cfgWrData);
  assign selOk       = (32'(cfgWrSel) < NUM_SRC);
  assign hitReserved = RESERVED[newRoute.slot];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routes   <= '0;
      coreMask <= '0;
      routeErr <= 1'b0;
    end else begin
      if (cfgWrEn && selOk) begin
        if (hitReserved) routeErr <= 1'b1;
        else routes[cfgWrSel] <= newRoute;
      end
      if (maskWrEn) coreMask[maskWrCore] <= maskWrData;
    end
  end

  always_comb begin
    strobe.clrBits = clrWrData;
    for (int c = 0; c < NUM_CORES; c++)
      strobe.clrHit[c] = clrWrEn && (clrWrCore == 1'(c));
  end

  // R6: a write to a reserved slot raises the flag
  assert_reserved_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && selOk && hitReserved) |=> routeErr);

  // R6: the flag never falls outside reset
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    routeErr |=> routeErr);
endmodule

// File: rtl/irq_slot_path.sv
module irq_slot_path
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SLOTS*LVL_W-1:0]    SLOT_LEVEL = defaultLevels(),
  parameter logic [NUM_SLOTS-1:0]          SLOT_EDGE  = defaultEdges(),
  parameter logic [INT_PER_CORE*SLOT_W-1:0] INT_SLOTS = defaultIntSlots()
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic [NUM_SRC-1:0]                   extReq,
  input  logic [NUM_CORES-1:0][INT_PER_CORE-1:0] intReq,
  input  route_t [NUM_SRC-1:0]                 routes,
  input  logic [NUM_CORES-1:0][NUM_SLOTS-1:0]  coreMask,
  input  strobe_t                              strobe,
  output logic [NUM_CORES-1:0]                 pickValid,
  output logic [NUM_CORES-1:0][SLOT_W-1:0]     pickSlot,
  output logic [NUM_CORES-1:0][LVL_W-1:0]      pickLevel
);
  logic [NUM_CORES-1:0][NUM_SLOTS-1:0] slotIn;
  logic [NUM_CORES-1:0][NUM_SLOTS-1:0] slotInQ;
  logic [NUM_CORES-1:0][NUM_SLOTS-1:0] pend;
  logic [NUM_CORES-1:0][NUM_SLOTS-1:0] pendNext;

  // combine routed external lines and hard-wired internal lines
  always_comb begin
    slotIn = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (routes[i].en)
        slotIn[routes[i].core][routes[i].slot] =
          slotIn[routes[i].core][routes[i].slot] | extReq[i];
    end
    for (int c = 0; c < NUM_CORES; c++) begin
      for (int k = 0; k < INT_PER_CORE; k++)
        slotIn[c][INT_SLOTS[k*SLOT_W +: SLOT_W]] =
          slotIn[c][INT_SLOTS[k*SLOT_W +: SLOT_W]] | intReq[c][k];
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      logic [NUM_SLOTS-1:0] clrMask;
      logic [NUM_SLOTS-1:0] edgeState;
      clrMask   = strobe.clrHit[c] ? strobe.clrBits : '0;
      edgeState = (pend[c] & ~clrMask) | (slotIn[c] & ~slotInQ[c]);
      pendNext[c] = (SLOT_EDGE & edgeState) | (~SLOT_EDGE & slotIn[c]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend    <= '0;
      slotInQ <= '0;
    end else begin
      pend    <= pendNext;
      slotInQ <= slotIn;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    irq_pick #(.SLOT_LEVEL(SLOT_LEVEL)) u_pick (
      .cand      (pend[c] & coreMask[c]),
      .pickValid (pickValid[c]),
      .pickSlot  (pickSlot[c]),
      .pickLevel (pickLevel[c])
    );

    // R9: a winner is pending, enabled and reports its own level
    assert_pick_sane_R9: assert property (@(posedge clk) disable iff (!rstN)
      pickValid[c] |-> (pend[c][pickSlot[c]] && coreMask[c][pickSlot[c]] &&
                        pickLevel[c] == SLOT_LEVEL[pickSlot[c]*LVL_W +: LVL_W]));

    // R9: no winner means nothing qualifies
    assert_pick_none_R9: assert property (@(posedge clk) disable iff (!rstN)
      !pickValid[c] |-> ((pend[c] & coreMask[c]) == '0));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      if (SLOT_EDGE[s]) begin : g_edge
        // R4: a rising input is latched
        assert_edge_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
          (slotIn[c][s] && !slotInQ[c][s]) |=> pend[c][s]);
        // R4: a latched bit holds until cleared
        assert_edge_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
          (pend[c][s] && !(strobe.clrHit[c] && strobe.clrBits[s])) |=> pend[c][s]);
      end else begin : g_lvl
        // R3, R5: level slot follows its input one clock later
        assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
          $past(rstN) |-> (pend[c][s] == $past(slotIn[c][s])));
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter logic [NUM_SLOTS*LVL_W-1:0]    SLOT_LEVEL = defaultLevels(),
  parameter logic [NUM_SLOTS-1:0]          SLOT_EDGE  = defaultEdges(),
  parameter logic [INT_PER_CORE*SLOT_W-1:0] INT_SLOTS = defaultIntSlots()
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_SRC-1:0]          extReq,
  input  logic [5:0]                  core0IntReq,
  input  logic [5:0]                  core1IntReq,
  input  logic                        cfgWrEn,
  input  logic [$clog2(NUM_SRC)-1:0]  cfgWrSel,
  input  logic [6:0]                  cfgWrData,
  input  logic                        maskWrEn,
  input  logic                        maskWrCore,
  input  logic [31:0]                 maskWrData,
  input  logic                        clrWrEn,
  input  logic                        clrWrCore,
  input  logic [31:0]                 clrWrData,
  output logic                        routeErr,
  output logic                        core0Valid,
  output logic [4:0]                  core0Slot,
  output logic [2:0]                  core0Level,
  output logic                        core1Valid,
  output logic [4:0]                  core1Slot,
  output logic [2:0]                  core1Level
);
  route_t [NUM_SRC-1:0]                  routes;
  logic [NUM_CORES-1:0][NUM_SLOTS-1:0]   coreMask;
  strobe_t                               strobe;
  logic [NUM_CORES-1:0][INT_PER_CORE-1:0] intReq;
  logic [NUM_CORES-1:0]                  pickValid;
  logic [NUM_CORES-1:0][SLOT_W-1:0]      pickSlot;
  logic [NUM_CORES-1:0][LVL_W-1:0]       pickLevel;

  assign intReq[0] = core0IntReq;
  assign intReq[1] = core1IntReq;

  irq_route_ctrl #(.NUM_SRC(NUM_SRC), .INT_SLOTS(INT_SLOTS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrSel   (cfgWrSel),
    .cfgWrData  (cfgWrData),
    .maskWrEn   (maskWrEn),
    .maskWrCore (maskWrCore),
    .maskWrData (maskWrData),
    .clrWrEn    (clrWrEn),
    .clrWrCore  (clrWrCore),
    .clrWrData  (clrWrData),
    .routes     (routes),
    .coreMask   (coreMask),
    .strobe     (strobe),
    .routeErr   (routeErr)
  );

  irq_slot_path #(
    .NUM_SRC(NUM_SRC), .SLOT_LEVEL(SLOT_LEVEL),
    .SLOT_EDGE(SLOT_EDGE), .INT_SLOTS(INT_SLOTS)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .extReq    (extReq),
    .intReq    (intReq),
    .routes    (routes),
    .coreMask  (coreMask),
    .strobe    (strobe),
    .pickValid (pickValid),
    .pickSlot  (pickSlot),
    .pickLevel (pickLevel)
  );

  assign core0Valid = pickValid[0];
  assign core0Slot  = pickSlot[0];
  assign core0Level = pickLevel[0];
  assign core1Valid = pickValid[1];
  assign core1Slot  = pickSlot[1];
  assign core1Level = pickLevel[1];

  // R1: both cores idle in the first cycle after reset
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!core0Valid && !core1Valid && !routeErr));
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
  localparam int NSRC = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [NSRC-1:0] extReq = '0;
  logic [5:0]  core0IntReq = '0, core1IntReq = '0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrSel = '0;
  logic [6:0]  cfgWrData = '0;
  logic        maskWrEn = 1'b0, maskWrCore = 1'b0;
  logic [31:0] maskWrData = '0;
  logic        clrWrEn = 1'b0, clrWrCore = 1'b0;
  logic [31:0] clrWrData = '0;
  logic        routeErr, core0Valid, core1Valid;
  logic [4:0]  core0Slot, core1Slot;
  logic [2:0]  core0Level, core1Level;

  always #10 clk = ~clk;

  irq_router #(.NUM_SRC(NSRC)) u_irq_router (
    .clk(clk), .rstN(rstN), .extReq(extReq),
    .core0IntReq(core0IntReq), .core1IntReq(core1IntReq),
    .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel), .cfgWrData(cfgWrData),
    .maskWrEn(maskWrEn), .maskWrCore(maskWrCore), .maskWrData(maskWrData),
    .clrWrEn(clrWrEn), .clrWrCore(clrWrCore), .clrWrData(clrWrData),
    .routeErr(routeErr),
    .core0Valid(core0Valid), .core0Slot(core0Slot), .core0Level(core0Level),
    .core1Valid(core1Valid), .core1Slot(core1Slot), .core1Level(core1Level)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;
  string phase = "R1";

  // R11 table, written independently
  function automatic int lvlOf(int s);
    if (s <= 9 || (s >= 24 && s <= 26) || s == 30) return 1;
    if (s <= 13) return 2;
    if (s <= 17 || s == 27 || s == 31) return 3;
    if (s <= 19) return 4;
    if (s <= 21 || s == 28) return 5;
    if (s == 22) return 6;
    return 7;
  endfunction
  function automatic bit isEdge(int s);
    return s == 8 || s == 9 || s == 13 || s == 17 || s == 20 ||
           s == 26 || s == 27 || s == 28 || s == 30;
  endfunction

  // behavioural model state
  bit mEn[NSRC];
  int mCore[NSRC];
  int mSlot[NSRC];
  bit [31:0] mMask[2];
  bit mPend[2][32];
  bit mPrev[2][32];
  bit mErr;

  always @(posedge clk) begin
    bit inV[2][32];
    if (!rstN) begin
      foreach (mEn[i]) begin mEn[i] = 0; mCore[i] = 0; mSlot[i] = 0; end
      mMask[0] = 0; mMask[1] = 0; mErr = 0;
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 32; s++) begin mPend[c][s] = 0; mPrev[c][s] = 0; end
    end else begin
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 32; s++) inV[c][s] = 0;
      for (int i = 0; i < NSRC; i++)
        if (mEn[i] && extReq[i]) inV[mCore[i]][mSlot[i]] = 1;
      for (int k = 0; k < 6; k++) begin
        if (core0IntReq[k]) inV[0][26+k] = 1;
        if (core1IntReq[k]) inV[1][26+k] = 1;
      end
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < 32; s++) begin
          if (isEdge(s)) begin
            if (clrWrEn && clrWrCore == c && clrWrData[s]) mPend[c][s] = 0;
            if (inV[c][s] && !mPrev[c][s]) mPend[c][s] = 1;
          end else mPend[c][s] = inV[c][s];
          mPrev[c][s] = inV[c][s];
        end
      if (cfgWrEn) begin
        if (cfgWrData[4:0] >= 26) mErr = 1;
        else begin
          mEn[cfgWrSel] = cfgWrData[6];
          mCore[cfgWrSel] = cfgWrData[5];
          mSlot[cfgWrSel] = cfgWrData[4:0];
        end
      end
      if (maskWrEn) mMask[maskWrCore] = maskWrData;
    end
  end

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // compare against the model every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < 2; c++) begin
        bit v; int bs; int bl;
        v = 0; bs = 0; bl = 0;
        for (int s = 0; s < 32; s++)
          if (mPend[c][s] && mMask[c][s] && (!v || lvlOf(s) > bl)) begin
            v = 1; bs = s; bl = lvlOf(s);
          end
        check(phase, $sformatf("model core%0d valid", c),
              c == 0 ? int'(core0Valid) : int'(core1Valid), v);
        if (v) begin
          check(phase, $sformatf("model core%0d slot", c),
                c == 0 ? int'(core0Slot) : int'(core1Slot), bs);
          check(phase, $sformatf("model core%0d level", c),
                c == 0 ? int'(core0Level) : int'(core1Level), bl);
        end
      end
      check(phase, "model routeErr", routeErr, mErr);
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      summary();
      $finish;
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic route(int src, int data);
    cfgWrEn = 1; cfgWrSel = 3'(src); cfgWrData = 7'(data);
    cyc(); cfgWrEn = 0;
  endtask
  task automatic setMask(int core, logic [31:0] m);
    maskWrEn = 1; maskWrCore = core[0]; maskWrData = m;
    cyc(); maskWrEn = 0;
  endtask
  task automatic clr(int core, logic [31:0] m);
    clrWrEn = 1; clrWrCore = core[0]; clrWrData = m;
    cyc(); clrWrEn = 0;
  endtask
  task automatic expect0(string tag, bit v, int s, int l);
    check(tag, "core0 valid", core0Valid, v);
    if (v) begin check(tag, "core0 slot", core0Slot, s); check(tag, "core0 level", core0Level, l); end
  endtask
  task automatic expect1(string tag, bit v, int s, int l);
    check(tag, "core1 valid", core1Valid, v);
    if (v) begin check(tag, "core1 slot", core1Slot, s); check(tag, "core1 level", core1Level, l); end
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1;
    cyc();
    phase = "R1";
    expect0("R1", 0, 0, 0); expect1("R1", 0, 0, 0);
    check("R1", "routeErr", routeErr, 0);
    extReq = '1; cyc(); cyc();
    expect0("R1", 0, 0, 0); // routes disabled, masks zero
    extReq = '0;

    phase = "R2";
    setMask(0, 32'hFFFF_FFFF); setMask(1, 32'hFFFF_FFFF);
    route(0, 7'h43); route(1, 7'h43); route(2, 7'h25); route(3, 7'h48);
    route(4, 7'h76); route(5, 7'h6A); route(6, 7'h6B); route(7, 7'h54);
    cyc();

    phase = "R3";
    extReq[0] = 1; cyc(); expect0("R3", 1, 3, 1); expect1("R2", 0, 0, 0);
    extReq[1] = 1; extReq[0] = 0; cyc(); expect0("R3", 1, 3, 1);
    extReq[1] = 0; cyc(); expect0("R3", 0, 0, 0);

    phase = "R8";
    extReq[2] = 1; cyc(); cyc(); expect1("R8", 0, 0, 0); expect0("R8", 0, 0, 0);
    extReq[2] = 0; cyc();

    phase = "R4";
    extReq[3] = 1; cyc(); expect0("R4", 1, 8, 1);
    extReq[3] = 0; cyc(); cyc(); expect0("R4", 1, 8, 1);
    clr(0, 32'h100); expect0("R4", 0, 0, 0);
    extReq[3] = 1; cyc(); extReq[3] = 0; cyc(); extReq[3] = 1; cyc(); extReq[3] = 0; cyc();
    clr(0, 32'h100); expect0("R4", 0, 0, 0);
    extReq[3] = 1; clr(0, 32'h100); expect0("R4", 1, 8, 1);
    extReq[3] = 0; clr(0, 32'h100); expect0("R4", 0, 0, 0);

    phase = "R5";
    extReq[0] = 1; cyc(); clr(0, 32'h8); expect0("R5", 1, 3, 1);
    cyc(); expect0("R5", 1, 3, 1);
    extReq[0] = 0; cyc();

    phase = "R9";
    extReq[5] = 1; extReq[6] = 1; cyc(); expect1("R9", 1, 10, 2);
    extReq[4] = 1; cyc(); expect1("R9", 1, 22, 6);

    phase = "R10";
    setMask(1, ~32'h0040_0000); expect1("R10", 1, 10, 2);
    setMask(1, ~32'h0040_0400); expect1("R10", 1, 11, 2);
    setMask(1, 32'hFFFF_FFFF); expect1("R10", 1, 22, 6);
    extReq[4] = 0; extReq[5] = 0; extReq[6] = 0; cyc();

    phase = "R6";
    route(0, 7'h5B); check("R6", "routeErr set", routeErr, 1);
    extReq[0] = 1; cyc(); expect0("R6", 1, 3, 1);
    extReq[0] = 0; cyc(); cyc(); check("R6", "routeErr sticky", routeErr, 1);

    phase = "R7";
    core1IntReq = 6'b001000; cyc(); expect1("R7", 1, 29, 7); expect0("R7", 0, 0, 0);
    core1IntReq = 0; core0IntReq = 6'b000010; cyc(); expect0("R7", 1, 27, 3);
    expect1("R7", 0, 0, 0);
    core0IntReq = 0; clr(0, 32'h0800_0000); expect0("R7", 0, 0, 0);

    phase = "R11";
    for (int n = 0; n < 600; n++) begin
      extReq = 8'($urandom);
      core0IntReq = 6'($urandom); core1IntReq = 6'($urandom);
      cfgWrEn = ($urandom % 8) == 0; cfgWrSel = 3'($urandom); cfgWrData = 7'($urandom);
      maskWrEn = ($urandom % 16) == 0; maskWrCore = 1'($urandom);
      maskWrData = ($urandom % 2) ? 32'hFFFF_FFFF : 32'($urandom);
      clrWrEn = ($urandom % 4) == 0; clrWrCore = 1'($urandom); clrWrData = 32'($urandom);
      cyc();
    end
    cfgWrEn = 0; maskWrEn = 0; clrWrEn = 0; extReq = 0;
    cyc(); cyc();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule